// File: doc/BRIEF.md
# Masked Alert Interrupt Controller

This block merges three fault and limit events into one alert output. The events are an internal-sensor high-limit crossing, an external-sensor high-limit crossing and an open-circuit fault on the remote sensing diode. Each event arrives as a level input. The block samples those levels only when the conversion logic pulses `conv_done` for one cycle. An event that is present at such a strobe, and that is not masked, sets a sticky alert latch. The latch stays set until software clears it.

Two 8-bit registers sit behind a plain write/read port. Address 0 is the configuration register, which holds the output polarity and a write-one alert-clear command. Address 1 is the mask register, which holds one mask bit for each event. Writes take effect on the clock edge at which `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no handshake: every write is accepted in the cycle it is presented.

Top module: `alert_irq_ctrl`

## Requirements
- R1: After reset, `alert_o` is 1 (inactive, because the polarity is active-low), and both registers read 0.
- R2: Configuration bit 4 sets the polarity. When it is 0, `alert_o` is low while the latch is set and high otherwise. When it is 1, `alert_o` follows the latch directly.
- R3: Writing address 0 with bit 3 at 1 clears the latch on that edge. Bit 3 always reads back as 0.
- R4: Configuration bits 7:5 and 3:0 are not held. They read as 0 whatever was written.
- R5: Mask bit 7 blocks the internal high-limit event, bit 6 the external high-limit event and bit 5 the open-circuit event. A 1 blocks the event, and these bits read back as written.
- R6: Mask bits 4:0 read as 0, and writing them changes neither the read value nor the alert behaviour.
- R7: The latch sets only on a clock edge where `conv_done` is 1 and at least one unmasked event input is 1. Events held without a strobe do not set it.
- R8: Once set, the latch stays set through later strobes with no event and through mask changes, until an alert clear is written.
- R9: If an alert clear and a strobe with an unmasked event fall on the same edge, the clear wins and the latch stays clear. The next strobe with an unmasked event sets it again.
- R10: `alert_o` reflects a strobe or a register write from the clock edge at which it is captured, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register select: 0 configuration, 1 mask |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| evt_int_hi | input | 1 | Internal-sensor high-limit event level |
| evt_ext_hi | input | 1 | External-sensor high-limit event level |
| evt_open | input | 1 | Remote-diode open-circuit event level |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| alert_o | output | 1 | Alert output, active level set by polarity |

## Verification
The hardest state to reach is an alert clear and a qualifying strobe landing on the same edge. The bench drives `reg_wr` and `conv_done` from the same falling edge while every event input is high and unmasked. It then checks that the output stays inactive, and that a lone strobe afterwards sets the alert. Sticky behaviour is reached by sweeping all polarity, mask and event combinations, with a second strobe at which the events are removed.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int NUM_EVT   = 3;
  localparam int POL_BIT   = 4;
  localparam int CLR_BIT   = 3;
  localparam int MASK_TOP  = 7;
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_MASK = 1;

  typedef struct packed {
    logic int_hi;
    logic ext_hi;
    logic open_ckt;
  } evt_t;
endpackage

// File: rtl/alert_regfile.sv
module alert_regfile
  import alert_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               pol,
  output logic [NUM_EVT-1:0] mask,
  output logic               clr_pulse
);
  localparam int MASK_LO = MASK_TOP - NUM_EVT + 1;

  logic cfg_sel, mask_sel;
  logic pol_q;
  logic [NUM_EVT-1:0] mask_q;
  logic unused_wbits;

  assign cfg_sel   = (addr == ADDR_W'(ADDR_CFG));
  assign mask_sel  = (addr == ADDR_W'(ADDR_MASK));
  assign clr_pulse = wr && cfg_sel && wdata[CLR_BIT];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      mask_q <= '0;
    end else if (wr) begin
      if (cfg_sel)  pol_q  <= wdata[POL_BIT];
      if (mask_sel) mask_q <= wdata[MASK_TOP:MASK_LO];
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_sel)       rdata[POL_BIT] = pol_q;
    else if (mask_sel) rdata[MASK_TOP:MASK_LO] = mask_q;
  end

  assign pol  = pol_q;
  assign mask = mask_q;
endmodule

// File: rtl/alert_evt_gate.sv
module alert_evt_gate
  import alert_pkg::*;
#(
  parameter int N = NUM_EVT
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] mask,
  output logic         hit
);
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_evt
    assign live[i] = evt[i] & ~mask[i];
  end

  assign hit = |live;
endmodule

// File: rtl/alert_latch.sv
module alert_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic hit,
  input  logic clr,
  input  logic pol,
  output logic state,
  output logic pin
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= 1'b0;
    else if (clr)            q <= 1'b0;
    else if (strobe && hit)  q <= 1'b1;
  end

  assign state = q;
  assign pin   = q ^ ~pol;
endmodule

// File: rtl/alert_irq_ctrl.sv
module alert_irq_ctrl
  import alert_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_int_hi,
  input  logic              evt_ext_hi,
  input  logic              evt_open,
  input  logic              conv_done,
  output logic              alert_o
);
  evt_t               evt;
  logic [NUM_EVT-1:0] mask;
  logic               pol, clr_pulse, hit_any, latch_q;

  assign evt = '{int_hi: evt_int_hi, ext_hi: evt_ext_hi, open_ckt: evt_open};

  alert_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pol(pol), .mask(mask), .clr_pulse(clr_pulse)
  );

  alert_evt_gate #(.N(NUM_EVT)) u_gate (
    .evt(evt), .mask(mask), .hit(hit_any)
  );

  alert_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strobe(conv_done), .hit(hit_any),
    .clr(clr_pulse), .pol(pol), .state(latch_q), .pin(alert_o)
  );
endmodule

// File: rtl/alert_irq_ctrl_chk.sv
module alert_irq_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              conv_done,
  input logic              hit_any,
  input logic              latch_q,
  input logic              alert_o
);
  logic cfg_wr, clr_wr;
  assign cfg_wr = reg_wr && (reg_addr == ADDR_W'(0));
  assign clr_wr = cfg_wr && reg_wdata[3];

  // R3: a clear write leaves the output at the idle level of the new polarity
  p_clear_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (alert_o == !$past(reg_wdata[4])));

  // R4: unheld configuration bits read 0
  p_cfg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> (reg_rdata[7:5] == 3'b0 && reg_rdata[3:0] == 4'b0));

  // R6: reserved mask bits read 0
  p_mask_res_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> (reg_rdata[4:0] == 5'b0));

  // R7: without a strobe or a configuration write the output holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !cfg_wr) |=> $stable(alert_o));

  // R7: a strobe with an unmasked event sets the latch
  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && hit_any && !clr_wr) |=> latch_q);

  // R8: a set latch stays set until a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr_wr) |=> latch_q);

  // R9: clear wins over a coincident strobe
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !latch_q);
endmodule

bind alert_irq_ctrl alert_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
  .hit_any(hit_any), .latch_q(latch_q), .alert_o(alert_o)
);

// File: tb/alert_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alert_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [0:0] reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       evt_int_hi = 1'b0, evt_ext_hi = 1'b0, evt_open = 1'b0;
  logic       conv_done = 1'b0;
  logic       alert_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  alert_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_int_hi(evt_int_hi),
    .evt_ext_hi(evt_ext_hi), .evt_open(evt_open), .conv_done(conv_done),
    .alert_o(alert_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic strobe();
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic set_evt(input logic [2:0] e);
    {evt_int_hi, evt_ext_hi, evt_open} = e;
  endtask

  // expected output: active level equals polarity, idle is its inverse
  function automatic logic exp_pin(input logic latched, input logic pol);
    return latched ? pol : ~pol;
  endfunction

  initial begin
    logic [7:0] rd;
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 alert idle", {7'b0, alert_o}, 8'h01);
    rd_reg(1'b0, rd); check("R1 cfg read", rd, 8'h00);
    rd_reg(1'b1, rd); check("R1 mask read", rd, 8'h00);

    // R4 R3 R5 R6 read-back sweep over every write value
    for (int v = 0; v < 256; v++) begin
      wr_reg(1'b0, 8'(v));
      rd_reg(1'b0, rd);
      check("R4 R3 cfg readback", rd, {3'b0, 1'(v >> 4), 4'b0});
      wr_reg(1'b1, 8'(v));
      rd_reg(1'b1, rd);
      check("R5 R6 mask readback", rd, {3'(v >> 5), 5'b0});
    end

    // R2 R5 R7 R8 R10 sweep: polarity x mask x events
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 8; e++) begin
          logic hit;
          hit = |(3'(e) & ~3'(m));
          set_evt(3'b000);
          wr_reg(1'b0, {3'b0, 1'(p), 1'b1, 3'b0});
          check("R2 R3 idle after clear", {7'b0, alert_o}, {7'b0, ~1'(p)});
          wr_reg(1'b1, {3'(m), 5'h1F});          // reserved bits set: R6 no effect
          set_evt(3'(e));
          repeat (2) @(negedge clk);
          check("R7 no strobe no alert", {7'b0, alert_o}, {7'b0, ~1'(p)});
          @(negedge clk);
          conv_done = 1'b1;
          @(posedge clk); #1;
          check("R10 R5 R7 alert at strobe edge", {7'b0, alert_o}, {7'b0, exp_pin(hit, 1'(p))});
          @(negedge clk);
          conv_done = 1'b0;
          set_evt(3'b000);
          wr_reg(1'b1, 8'hE0);                    // mask everything: latch must stay
          strobe();
          check("R8 sticky", {7'b0, alert_o}, {7'b0, exp_pin(hit, 1'(p))});
        end
      end
    end

    // R9 clear coincident with qualifying strobe
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h18);                          // active high, clear
    set_evt(3'b111);
    strobe();
    check("R9 precondition set", {7'b0, alert_o}, 8'h01);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h18; conv_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; conv_done = 1'b0;
    check("R9 clear wins", {7'b0, alert_o}, 8'h00);
    repeat (3) @(negedge clk);
    check("R9 stays clear without strobe", {7'b0, alert_o}, 8'h00);
    strobe();
    check("R9 next strobe sets", {7'b0, alert_o}, 8'h01);

    // R2 polarity flip while latched inverts the pin
    wr_reg(1'b0, 8'h00);
    check("R2 latched active low", {7'b0, alert_o}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule